// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects eight interrupt lines for a 32-bit processor core and tells the core which one to take next. Each line has a latched flag. A flag is set by a rising edge on its external request input, or by a software trigger that names the line's number. The core sees a single request, `int_valid`, and a 3-bit number, `int_vec`, for the lowest-numbered line that is currently allowed through.

Lines 0 and 1 stand for reset and exception requests. They are always allowed through. Lines 2 to 7 get through only when their own enable bit is set and the global interrupt enable is on. Software reads and writes an enable register and a flag register through a small memory-mapped port. The core drives strobes that set or clear the global enable, accept an interrupt (acknowledge) and return from one. On acknowledge the controller clears the winning flag, saves the global enable and then clears it. On return it puts the saved value back.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the enable register, the flag register and the global enable all read 0, and `int_valid` is low.
- R2: A flag bit is set only by a 0-to-1 change of its request input seen between two clock edges. A request input held high does not set its flag again after the flag is cleared.
- R3: When `sw_trig` is high at a clock edge, the flag whose bit number equals `sw_vec` is set.
- R4: A register write to address 0x20004 clears each flag bit whose write-data bit (7:0) is 1 and leaves the other flag bits unchanged. If a flag is set by an edge or a trigger in the same cycle that it is cleared, it ends up set.
- R5: A write to address 0x20000 loads write-data bits 7:0 into the enable register. A read of 0x20000 returns the enable register, and a read of 0x20004 returns the flags, both in bits 7:0 with upper bits 0. Any other address reads 0, and writes to it change nothing.
- R6: A set flag for line 0 or 1 makes `int_valid` high regardless of the enable register and the global enable.
- R7: A set flag for a line from 2 to 7 raises a request only when that line's enable bit is 1 and the global enable is 1.
- R8: When several lines are pending, `int_vec` gives the lowest-numbered one.
- R9: `gie_set` turns the global enable on and `gie_clr` turns it off. If both are high in the same cycle, `gie_clr` wins.
- R10: `int_ack` while `int_valid` is high clears the flag at `int_vec`, saves the global enable and clears it. `int_ack` while `int_valid` is low has no effect. An acknowledge takes precedence over every other enable strobe in the same cycle.
- R11: `int_ret` without an effective acknowledge sets the global enable to the value saved by the last acknowledge (0 after reset). It takes precedence over `gie_set` and `gie_clr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 20 | Register port byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq_in | input | 8 | External request inputs, one per line |
| sw_trig | input | 1 | Software trigger strobe |
| sw_vec | input | 3 | Line number raised by the software trigger |
| gie_set | input | 1 | Turn the global enable on |
| gie_clr | input | 1 | Turn the global enable off |
| int_ack | input | 1 | Core accepts the presented interrupt |
| int_ret | input | 1 | Core returns from an interrupt |
| int_valid | output | 1 | An interrupt is pending |
| int_vec | output | 3 | Number of the winning line |
| gie | output | 1 | Current global enable |

## Verification
The bench goes after collisions in the same cycle. A write-to-clear that meets a new edge must leave the flag set, or an event is lost. If `gie_set` and `gie_clr` arrive together and the design lets set win, the core is left enabled when it asked to be masked. If an acknowledge arrives with nothing pending and the design still acts on it, the saved enable is overwritten, and a later return comes back disabled.

The bench also holds a request input high across an acknowledge. A design that triggers on level instead of on edges sets the flag again at once and fires the interrupt a second time. A mix of masked and unmasked lines, and of lines 0 and 1 pending while masking is in force, shows up any wrong priority order or any masking applied to lines 0 and 1. After the directed cases, a long stretch of random strobes and addresses is compared every cycle.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int PIC_LINES  = 8;
  localparam int PIC_NMI    = 2;
  localparam int PIC_DATA_W = 32;
  localparam int PIC_ADDR_W = 20;
  localparam logic [PIC_ADDR_W-1:0] PIC_EN_ADDR  = 20'h20000;
  localparam logic [PIC_ADDR_W-1:0] PIC_FLG_ADDR = 20'h20004;
endpackage

// File: rtl/pic_capture.sv
module pic_capture #(
  parameter int NUM_LINES = 8,
  localparam int VEC_W = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] lines,
  input  logic                 sw_trig,
  input  logic [VEC_W-1:0]     sw_vec,
  input  logic [NUM_LINES-1:0] clr_mask,
  output logic [NUM_LINES-1:0] flags_q
);
  logic [NUM_LINES-1:0] prev_q;
  logic [NUM_LINES-1:0] rise;
  logic [NUM_LINES-1:0] sw_set;
  logic [NUM_LINES-1:0] flags_d;

  always_comb begin
    rise    = lines & ~prev_q;
    sw_set  = sw_trig ? ({{(NUM_LINES-1){1'b0}}, 1'b1} << sw_vec) : '0;
    // setting sources override a clear in the same cycle
    flags_d = (flags_q & ~clr_mask) | rise | sw_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      flags_q <= '0;
    end else begin
      prev_q  <= lines;
      flags_q <= flags_d;
    end
  end
endmodule

// File: rtl/pic_gie.sv
module pic_gie (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic take_i,
  input  logic ret_i,
  output logic gie_q
);
  logic sav_q, sav_d, gie_d, sav_en;

  always_comb begin
    sav_en = take_i;
    sav_d  = gie_q;
    if (take_i)     gie_d = 1'b0;
    else if (ret_i) gie_d = sav_q;
    else if (clr_i) gie_d = 1'b0;
    else if (set_i) gie_d = 1'b1;
    else            gie_d = gie_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q <= 1'b0;
      sav_q <= 1'b0;
    end else begin
      gie_q <= gie_d;
      if (sav_en) sav_q <= sav_d;
    end
  end
endmodule

// File: rtl/pic_select.sv
module pic_select #(
  parameter int NUM_LINES = 8,
  parameter int NUM_NMI   = 2,
  localparam int VEC_W = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0] flags,
  input  logic [NUM_LINES-1:0] en,
  input  logic                 gie,
  output logic                 valid,
  output logic [VEC_W-1:0]     vec
);
  logic [NUM_LINES-1:0] pend;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    if (g < NUM_NMI) begin : g_nmi
      assign pend[g] = flags[g];
    end else begin : g_msk
      assign pend[g] = flags[g] & en[g] & gie;
    end
  end

  always_comb begin
    valid = |pend;
    vec   = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (pend[i]) vec = VEC_W'(i);
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_LINES = PIC_LINES,
  parameter int NUM_NMI   = PIC_NMI,
  parameter int DATA_W    = PIC_DATA_W,
  parameter int ADDR_W    = PIC_ADDR_W,
  parameter logic [ADDR_W-1:0] EN_ADDR  = PIC_EN_ADDR,
  parameter logic [ADDR_W-1:0] FLG_ADDR = PIC_FLG_ADDR,
  localparam int VEC_W = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic                 reg_wr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 sw_trig,
  input  logic [VEC_W-1:0]     sw_vec,
  input  logic                 gie_set,
  input  logic                 gie_clr,
  input  logic                 int_ack,
  input  logic                 int_ret,
  output logic                 int_valid,
  output logic [VEC_W-1:0]     int_vec,
  output logic                 gie
);
  logic [NUM_LINES-1:0] en_q, en_d, flags_q, clr_mask;
  logic                 en_we, sel_en, sel_flg, take;
  logic                 unused_wbits;

  assign unused_wbits = ^reg_wdata[DATA_W-1:NUM_LINES];

  always_comb begin
    sel_en   = (reg_addr == EN_ADDR);
    sel_flg  = (reg_addr == FLG_ADDR);
    en_we    = reg_wr & sel_en;
    en_d     = reg_wdata[NUM_LINES-1:0];
    take     = int_ack & int_valid;
    clr_mask = (reg_wr & sel_flg) ? reg_wdata[NUM_LINES-1:0] : '0;
    if (take) clr_mask = clr_mask | ({{(NUM_LINES-1){1'b0}}, 1'b1} << int_vec);
    reg_rdata = '0;
    if (sel_en)       reg_rdata[NUM_LINES-1:0] = en_q;
    else if (sel_flg) reg_rdata[NUM_LINES-1:0] = flags_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_we) en_q <= en_d;
  end

  pic_capture #(.NUM_LINES(NUM_LINES)) u_capture (
    .clk(clk), .rst_n(rst_n), .lines(irq_in), .sw_trig(sw_trig),
    .sw_vec(sw_vec), .clr_mask(clr_mask), .flags_q(flags_q)
  );

  pic_gie u_gie (
    .clk(clk), .rst_n(rst_n), .set_i(gie_set), .clr_i(gie_clr),
    .take_i(take), .ret_i(int_ret), .gie_q(gie)
  );

  pic_select #(.NUM_LINES(NUM_LINES), .NUM_NMI(NUM_NMI)) u_select (
    .flags(flags_q), .en(en_q), .gie(gie), .valid(int_valid), .vec(int_vec)
  );
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk #(
  parameter int NUM_LINES = 8,
  parameter int NUM_NMI   = 2,
  localparam int VEC_W = $clog2(NUM_LINES)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 int_valid,
  input logic [VEC_W-1:0]     int_vec,
  input logic                 gie,
  input logic                 gie_set,
  input logic                 gie_clr,
  input logic                 int_ack,
  input logic                 int_ret,
  input logic [NUM_LINES-1:0] flags_q,
  input logic [NUM_LINES-1:0] en_q
);
  // R10
  ack_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && int_valid) |=> !gie);
  // R9
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gie_clr && !int_ack && !int_ret) |=> !gie);
  // R9
  set_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gie_set && !gie_clr && !int_ack && !int_ret) |=> gie);
  // R6
  nmi_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|flags_q[NUM_NMI-1:0]) |-> (int_valid && int_vec < VEC_W'(NUM_NMI)));
  // R7
  masked_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_valid && int_vec >= VEC_W'(NUM_NMI)) |-> (gie && en_q[int_vec]));
  // R8
  winner_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_valid |-> flags_q[int_vec]);
endmodule

bind prio_irq_ctrl prio_irq_chk #(.NUM_LINES(NUM_LINES), .NUM_NMI(NUM_NMI)) u_prio_irq_chk (
  .clk(clk), .rst_n(rst_n), .int_valid(int_valid), .int_vec(int_vec), .gie(gie),
  .gie_set(gie_set), .gie_clr(gie_clr), .int_ack(int_ack), .int_ret(int_ret),
  .flags_q(flags_q), .en_q(en_q)
);

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/1ps
module test_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [19:0] reg_addr;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [7:0]  irq_in;
  logic        sw_trig;
  logic [2:0]  sw_vec;
  logic        gie_set, gie_clr, int_ack, int_ret;
  logic        int_valid;
  logic [2:0]  int_vec;
  logic        gie;

  always #5 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in),
    .sw_trig(sw_trig), .sw_vec(sw_vec), .gie_set(gie_set), .gie_clr(gie_clr),
    .int_ack(int_ack), .int_ret(int_ret), .int_valid(int_valid),
    .int_vec(int_vec), .gie(gie)
  );

  // reference model state
  bit [7:0] m_en, m_flags, m_prev;
  bit       m_i, m_sav;
  int       n_vec = 0, n_bad = 0;
  bit       done = 0;
  string    cur_req = "R1";

  function automatic void model_out(output bit v, output int vc);
    v = 0; vc = 0;
    for (int k = 7; k >= 0; k--) begin
      if (m_flags[k] && (k < 2 || (m_en[k] && m_i))) begin
        v = 1; vc = k;
      end
    end
  endfunction

  function automatic bit [31:0] model_rd();
    if (reg_addr == 20'h20000) return {24'd0, m_en};
    if (reg_addr == 20'h20004) return {24'd0, m_flags};
    return 32'd0;
  endfunction

  task automatic compare();
    bit v; int vc; bit [31:0] rd;
    model_out(v, vc);
    rd = model_rd();
    n_vec++;
    if (int_valid !== v || (v && int_vec !== 3'(vc)) || gie !== m_i || reg_rdata !== rd) begin
      n_bad++;
      $display("FAIL %s: valid/vec/gie/rdata act %0b/%0d/%0b/%h exp %0b/%0d/%0b/%h",
               cur_req, int_valid, int_vec, gie, reg_rdata, v, vc, m_i, rd);
    end
  endtask

  task automatic model_step();
    bit v; int vc; bit take; bit [7:0] clr;
    model_out(v, vc);
    take = int_ack && v;
    clr = (reg_wr && reg_addr == 20'h20004) ? reg_wdata[7:0] : 8'd0;
    if (take) clr[vc] = 1'b1;
    if (reg_wr && reg_addr == 20'h20000) m_en = reg_wdata[7:0];
    m_flags = (m_flags & ~clr) | (irq_in & ~m_prev);
    if (sw_trig) m_flags[sw_vec] = 1'b1;
    m_prev = irq_in;
    if (take) begin m_sav = m_i; m_i = 0; end
    else if (int_ret) m_i = m_sav;
    else if (gie_clr) m_i = 0;
    else if (gie_set) m_i = 1;
  endtask

  task automatic idle();
    reg_wr = 0; reg_wdata = '0; sw_trig = 0; sw_vec = '0;
    gie_set = 0; gie_clr = 0; int_ack = 0; int_ret = 0;
  endtask

  // inputs already driven at negedge: check, then clock
  task automatic cyc();
    #1 compare();
    @(posedge clk);
    #1 model_step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [19:0] a, input logic [31:0] d);
    reg_addr = a; reg_wr = 1; reg_wdata = d; cyc(); idle();
  endtask

  task automatic rd(input logic [19:0] a);
    reg_addr = a; cyc();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: act hung exp finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; irq_in = '0; reg_addr = 20'h20000; idle();
    m_en = 0; m_flags = 0; m_prev = 0; m_i = 0; m_sav = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    cur_req = "R1"; rd(20'h20000); rd(20'h20004);
    // R5 register map
    cur_req = "R5";
    wr(20'h20000, 32'hFFFF_FFFC); rd(20'h20000);
    wr(20'h20008, 32'h0000_00FF); rd(20'h20008); rd(20'h20000); rd(20'h20004);
    // R7 masked while global enable off
    cur_req = "R7"; irq_in[5] = 1; rd(20'h20004); rd(20'h20004);
    // R9 enable on
    cur_req = "R9"; gie_set = 1; cyc(); idle(); cyc();
    // R8 lower line wins
    cur_req = "R8"; irq_in[3] = 1; cyc(); cyc();
    // R10 acknowledge with line 3 held high
    cur_req = "R10"; int_ack = 1; cyc(); idle(); rd(20'h20004);
    // R2 held level does not re-flag
    cur_req = "R2"; cyc(); cyc();
    // R11 return restores enable
    cur_req = "R11"; int_ret = 1; cyc(); idle(); cyc();
    // R6 line 1 bypasses masking
    cur_req = "R6"; gie_clr = 1; cyc(); idle(); wr(20'h20000, 0);
    irq_in[1] = 1; cyc(); cyc();
    // R4 write-one clears
    cur_req = "R4"; wr(20'h20004, 32'h0000_0002); rd(20'h20004);
    // R3 software trigger line 0 and 7
    cur_req = "R3"; sw_trig = 1; sw_vec = 3'd0; cyc(); idle(); cyc();
    sw_trig = 1; sw_vec = 3'd7; cyc(); idle(); rd(20'h20004);
    // R4 set beats clear in same cycle
    cur_req = "R4"; reg_addr = 20'h20004; reg_wr = 1; reg_wdata = 32'h80;
    sw_trig = 1; sw_vec = 3'd7; cyc(); idle(); rd(20'h20004);
    wr(20'h20004, 32'hFF); rd(20'h20004);
    // R10 acknowledge with nothing pending, then return
    cur_req = "R10"; gie_set = 1; cyc(); idle();
    int_ack = 1; cyc(); idle(); int_ret = 1; cyc(); idle(); cyc();
    // R9 set and clear together
    cur_req = "R9"; gie_set = 1; gie_clr = 1; cyc(); idle(); cyc();
    // random mix
    cur_req = "R8";
    irq_in = '0;
    for (int n = 0; n < 3000; n++) begin
      int sel;
      sel = $urandom_range(0, 2);
      reg_addr  = (sel == 0) ? 20'h20000 : (sel == 1) ? 20'h20004 : 20'h20010;
      reg_wr    = ($urandom_range(0, 7) == 0);
      reg_wdata = $urandom;
      irq_in    = ($urandom_range(0, 3) == 0) ? 8'($urandom) : irq_in;
      sw_trig   = ($urandom_range(0, 9) == 0);
      sw_vec    = 3'($urandom);
      gie_set   = ($urandom_range(0, 5) == 0);
      gie_clr   = ($urandom_range(0, 7) == 0);
      int_ack   = ($urandom_range(0, 3) == 0);
      int_ret   = ($urandom_range(0, 7) == 0);
      cyc();
    end
    idle(); cyc();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule